// File: doc/BRIEF.md
# SD Card Command and Response Engine

This block is the command-line half of an SD/MMC host controller. Software programs a command argument and a command index through a small word-addressed register port. It then writes the control word with the launch bit set. The engine builds the 48-bit command frame, appends its CRC7 and shifts the frame out MSB first, one bit for each pulse of the `sd_tick` bit-rate strobe. A 4-bit sequence-mode field then decides what follows: nothing, a 48-bit response, a 136-bit response, or a 48-bit response followed by a wait for the card to release DAT0. The mode field can also request a burst of initialization clocks with no command at all.

Responses are captured into four response words. A 48-bit response is checked against its CRC7. If no start bit arrives within the timeout window, a no-response error is flagged. Every sequence ends by setting a sticky done flag that software clears by writing 1 to it. The interrupt output is high while that flag and its enable bit are both set. Clock-rate generation, data-line transfers and DMA sit outside the block. The read-data and write-data modes are accepted and run only their command and response phase.

The sequencer states are IDLE, INIT (initialization clocks), SEND (frame shifting), WAIT (waiting for a response start bit), RECV (response capture), BUSY (waiting for DAT0 to go high) and DONE (one cycle that raises the done flag). The transitions are:
- IDLE→INIT when a launch requests mode 8, and IDLE→SEND for any other launch.
- INIT→DONE when the count is used up.
- SEND→DONE after the end bit when the mode takes no response, and SEND→WAIT otherwise.
- WAIT→RECV on a 0 bit, and WAIT→DONE on timeout.
- RECV→BUSY in mode 3, and RECV→DONE otherwise.
- BUSY→DONE when DAT0 is high.
- DONE→IDLE always.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset every register reads 0, and `cmd_oe`, `sdclk_en` and `irq` are low.
- R2: A launch drives the frame {0, 1, index[5:0], argument[31:0], CRC7, 1} on `cmd_out`, MSB first. The CRC7 uses polynomial x^7+x^3+1 over the first 40 bits. One bit is presented for each tick, and `cmd_oe` is high for exactly those 48 ticks.
- R3: Mode 0 ends the sequence right after the end bit, with no response window. Codes 6, 7 and 9 to 15 behave the same way.
- R4: Modes 1, 4 and 5 take a 48-bit response. Word 0 (address 4) gets frame bits [31:0], so the CRC byte lands in [7:0]. Word 1 (address 5) gets frame bits [47:32] in its bits [15:0].
- R5: A 48-bit response whose CRC7 field (bits [7:1]) does not match the CRC7 of bits [47:8] sets status bit 0.
- R6: If 64 ticks after the end bit pass with `cmd_in` high, status bit 4 is set and the sequence ends. A start bit that arrives on the 64th tick is still accepted.
- R7: Mode 2 takes a 136-bit response. Frame bits [127:96] go to word 0 (address 4) and bits [31:0] go to word 3 (address 7). Its CRC is not checked.
- R8: Mode 3 takes a 48-bit response and then ends only on a tick that sees `dat0_in` high.
- R9: Mode 8 keeps `sdclk_en` high for N ticks, where N is the count in control bits [11:8] (a count of 0 gives one tick). `cmd_oe` stays low.
- R10: Status bit 5 is set when a sequence ends and is cleared by writing 1 to it. `irq` equals status bit 5 AND status bit 6.
- R11: Every launch clears status bits 0 and 4.
- R12: A control write that arrives while a sequence runs (status bit 8 high) is ignored completely.
- R13: Control bits [23:16] keep the value software wrote, across sequences. The launch bit (7) reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write word address (0 arg, 1 index, 2 control, 3 status, 4-7 response) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | 32 | Read data (combinational) |
| sd_tick | input | 1 | One-cycle strobe per card clock |
| cmd_in | input | 1 | CMD line as seen from the card |
| dat0_in | input | 1 | DAT0 line level |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| sdclk_en | output | 1 | Card clock must run |
| irq | output | 1 | Done interrupt |

## Verification
A sequencer stuck in the wrong state shows on the ports within one tick. `cmd_oe` or `sdclk_en` takes the wrong level, or the done flag and `irq` appear too early or never. A miscounted bit or timeout counter shows up as a frame that is one bit long or short, or as a no-response flag raised on the wrong tick. A bad shift or capture alignment appears as a corrupted response word or a false CRC flag as soon as that sequence's done flag is set.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int KEEP_BITS  = 128;

    localparam logic [3:0] MODE_NORSP = 4'd0;
    localparam logic [3:0] MODE_SHORT = 4'd1;
    localparam logic [3:0] MODE_LONG  = 4'd2;
    localparam logic [3:0] MODE_BUSY  = 4'd3;
    localparam logic [3:0] MODE_RD    = 4'd4;
    localparam logic [3:0] MODE_WR    = 4'd5;
    localparam logic [3:0] MODE_INIT  = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_INIT, ST_SEND, ST_WAIT, ST_RECV, ST_BUSY, ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {RSP_NONE, RSP_SHORT, RSP_LONG} rsp_kind_e;

    function automatic rsp_kind_e rsp_kind(input logic [3:0] m);
        case (m)
            MODE_SHORT, MODE_BUSY, MODE_RD, MODE_WR: return RSP_SHORT;
            MODE_LONG:                               return RSP_LONG;
            default:                                 return RSP_NONE;
        endcase
    endfunction

    function automatic logic [6:0] crc7_calc(input logic [39:0] m);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            fb = m[i] ^ c[6];
            c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

endpackage

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
    import sd_cmd_pkg::*;
#(
    parameter int TMO_TICKS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sd_tick,
    input  logic                 go,
    input  logic [3:0]           mode,
    input  logic [5:0]           idx,
    input  logic [31:0]          arg,
    input  logic [3:0]           init_cnt,
    input  logic                 cmd_in,
    input  logic                 dat0_in,
    output logic                 cmd_out,
    output logic                 cmd_oe,
    output logic                 sdclk_en,
    output logic                 busy,
    output logic                 launch,
    output logic                 done,
    output logic                 set_noresp,
    output logic                 set_crcerr,
    output logic                 rsp_we,
    output logic                 rsp_long,
    output logic [KEEP_BITS-1:0] rsp_data
);
    localparam int CNT_W = $clog2(LONG_BITS);
    localparam int TMO_W = $clog2(TMO_TICKS + 1);

    seq_state_e            st_q, st_d;
    logic [FRAME_BITS-1:0] tx_q;
    logic [KEEP_BITS-1:0]  rx_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [TMO_W-1:0]      tmo_q;
    logic [3:0]            mode_q;
    logic                  rx_last, cap_q, tmo_hit;
    rsp_kind_e             kind;

    assign kind    = rsp_kind(mode_q);
    assign rx_last = (st_q == ST_RECV) && sd_tick && (cnt_q == CNT_W'(1));
    assign tmo_hit = (st_q == ST_WAIT) && sd_tick && cmd_in
                     && (tmo_q == TMO_W'(TMO_TICKS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (go) st_d = (mode == MODE_INIT) ? ST_INIT : ST_SEND;
            ST_INIT: if (sd_tick && cnt_q <= CNT_W'(1)) st_d = ST_DONE;
            ST_SEND: if (sd_tick && cnt_q == '0)
                         st_d = (kind == RSP_NONE) ? ST_DONE : ST_WAIT;
            ST_WAIT: if (sd_tick) begin
                         if (!cmd_in)     st_d = ST_RECV;
                         else if (tmo_hit) st_d = ST_DONE;
                     end
            ST_RECV: if (rx_last) st_d = (mode_q == MODE_BUSY) ? ST_BUSY : ST_DONE;
            ST_BUSY: if (sd_tick && dat0_in) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // datapath: frame shifter, capture register, counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            cnt_q  <= '0;
            tmo_q  <= '0;
            mode_q <= MODE_NORSP;
            cap_q  <= 1'b0;
        end else begin
            cap_q <= rx_last;
            if (st_q == ST_IDLE && go) begin
                mode_q <= mode;
                tx_q   <= {2'b01, idx, arg, crc7_calc({2'b01, idx, arg}), 1'b1};
                cnt_q  <= (mode == MODE_INIT) ? CNT_W'(init_cnt) : CNT_W'(FRAME_BITS - 1);
                tmo_q  <= '0;
                rx_q   <= '0;
            end else if (sd_tick) begin
                unique case (st_q)
                    ST_INIT: if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
                    ST_SEND: begin
                        tx_q <= tx_q << 1;
                        if (cnt_q == '0)
                            cnt_q <= (kind == RSP_LONG) ? CNT_W'(LONG_BITS - 1)
                                                        : CNT_W'(FRAME_BITS - 1);
                        else
                            cnt_q <= cnt_q - CNT_W'(1);
                    end
                    ST_WAIT: begin
                        tmo_q <= tmo_q + TMO_W'(1);
                        if (!cmd_in) rx_q <= {rx_q[KEEP_BITS-2:0], cmd_in};
                    end
                    ST_RECV: begin
                        rx_q  <= {rx_q[KEEP_BITS-2:0], cmd_in};
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        cmd_oe     = (st_q == ST_SEND);
        cmd_out    = (st_q == ST_SEND) ? tx_q[FRAME_BITS-1] : 1'b1;
        sdclk_en   = (st_q == ST_INIT) || (st_q == ST_SEND) || (st_q == ST_WAIT)
                     || (st_q == ST_RECV) || (st_q == ST_BUSY);
        busy       = (st_q != ST_IDLE);
        launch     = (st_q == ST_IDLE) && go;
        done       = (st_q == ST_DONE);
        set_noresp = tmo_hit;
        rsp_we     = cap_q;
        rsp_long   = (kind == RSP_LONG);
        rsp_data   = rx_q;
        set_crcerr = cap_q && (kind == RSP_SHORT)
                     && (crc7_calc(rx_q[47:8]) != rx_q[7:1]);
    end

    assert_init_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_INIT) |-> !cmd_oe);
    assert_drive_has_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> sdclk_en);
    assert_tmo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> (tmo_q < TMO_W'(TMO_TICKS)));
    assert_busy_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY) |-> (mode_q == MODE_BUSY));
    assert_launch_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go && st_q != ST_DONE) |=> $stable(mode_q));
endmodule

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
    import sd_cmd_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    input  logic                 seq_busy,
    input  logic                 launch,
    input  logic                 done,
    input  logic                 set_noresp,
    input  logic                 set_crcerr,
    input  logic                 rsp_we,
    input  logic                 rsp_long,
    input  logic [KEEP_BITS-1:0] rsp_data,
    output logic [31:0]          arg_q,
    output logic [5:0]           idx_q,
    output logic [3:0]           mode_q,
    output logic [3:0]           icnt_q,
    output logic                 go,
    output logic                 irq
);
    localparam logic [AW-1:0] A_ARG  = AW'(0);
    localparam logic [AW-1:0] A_IDX  = AW'(1);
    localparam logic [AW-1:0] A_CTRL = AW'(2);
    localparam logic [AW-1:0] A_STAT = AW'(3);
    localparam int NWORDS = 4;

    logic [7:0]              dly_q;
    logic                    crc_q, nrsp_q, end_q, ien_q;
    logic [NWORDS-1:0][31:0] rsp_q;
    logic                    ctrl_wr, stat_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL) && !seq_busy;
    assign stat_wr = wr_en && (wr_addr == A_STAT);
    assign go      = ctrl_wr && wr_data[7];
    assign irq     = end_q && ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q  <= '0;
            idx_q  <= '0;
            mode_q <= '0;
            icnt_q <= '0;
            dly_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_ARG) arg_q <= wr_data[31:0];
            if (wr_addr == A_IDX) idx_q <= wr_data[5:0];
            if (ctrl_wr) begin
                mode_q <= wr_data[3:0];
                icnt_q <= wr_data[11:8];
                dly_q  <= wr_data[23:16];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q  <= 1'b0;
            nrsp_q <= 1'b0;
            end_q  <= 1'b0;
            ien_q  <= 1'b0;
        end else begin
            if (stat_wr) ien_q <= wr_data[6];
            if (done) end_q <= 1'b1;
            else if (stat_wr && wr_data[5]) end_q <= 1'b0;
            if (launch) begin
                crc_q  <= 1'b0;
                nrsp_q <= 1'b0;
            end else begin
                if (set_crcerr) crc_q  <= 1'b1;
                if (set_noresp) nrsp_q <= 1'b1;
            end
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_rsp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rsp_q[w] <= '0;
            else if (rsp_we) begin
                if (rsp_long)    rsp_q[w] <= rsp_data[KEEP_BITS-1-32*w -: 32];
                else if (w == 0) rsp_q[w] <= rsp_data[31:0];
                else if (w == 1) rsp_q[w] <= {16'h0, rsp_data[47:32]};
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_ARG:  rd_data = DW'(arg_q);
            A_IDX:  rd_data = DW'(idx_q);
            A_CTRL: rd_data = DW'({dly_q, 4'h0, icnt_q, 4'h0, mode_q});
            A_STAT: rd_data = DW'({seq_busy, 1'b0, ien_q, end_q, nrsp_q, 3'b000, crc_q});
            default: rd_data = DW'(rsp_q[rd_addr[1:0]]);
        endcase
    end

    assert_done_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> end_q);
    assert_launch_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!crc_q && !nrsp_q));
    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wr_data[5] && !done) |=> !end_q);
    assert_ignore_busy_ctrl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && seq_busy) |=> $stable(dly_q));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int TMO_TICKS = 64,
    parameter int AW        = 3,
    parameter int DW        = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_waddr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [AW-1:0] reg_raddr,
    output logic [DW-1:0] reg_rdata,
    input  logic          sd_tick,
    input  logic          cmd_in,
    input  logic          dat0_in,
    output logic          cmd_out,
    output logic          cmd_oe,
    output logic          sdclk_en,
    output logic          irq
);
    logic [31:0]          arg;
    logic [5:0]           idx;
    logic [3:0]           mode, icnt;
    logic                 go, busy, launch, done, set_noresp, set_crcerr;
    logic                 rsp_we, rsp_long;
    logic [KEEP_BITS-1:0] rsp_data;

    sd_cmd_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_addr(reg_waddr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr), .rd_data(reg_rdata),
        .seq_busy(busy), .launch(launch), .done(done),
        .set_noresp(set_noresp), .set_crcerr(set_crcerr),
        .rsp_we(rsp_we), .rsp_long(rsp_long), .rsp_data(rsp_data),
        .arg_q(arg), .idx_q(idx), .mode_q(), .icnt_q(), .go(go), .irq(irq)
    );

    // the sequencer takes mode and count straight from the launching write
    assign mode = reg_wdata[3:0];
    assign icnt = reg_wdata[11:8];

    sd_cmd_seq #(.TMO_TICKS(TMO_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .go(go),
        .mode(mode), .idx(idx), .arg(arg), .init_cnt(icnt),
        .cmd_in(cmd_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .sdclk_en(sdclk_en),
        .busy(busy), .launch(launch), .done(done),
        .set_noresp(set_noresp), .set_crcerr(set_crcerr),
        .rsp_we(rsp_we), .rsp_long(rsp_long), .rsp_data(rsp_data)
    );
endmodule

// File: tb/tb_sd_cmd_engine.sv
module tb_sd_cmd_engine;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_waddr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sd_tick = 1'b0, cmd_in = 1'b1, dat0_in = 1'b1;
    logic        cmd_out, cmd_oe, sdclk_en, irq;
    logic        s_out, s_oe, s_ck;
    int          n_chk = 0, n_fail = 0;
    logic        exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    sd_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .sd_tick(sd_tick), .cmd_in(cmd_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .sdclk_en(sdclk_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // polynomial long division, independent of any shift-register form
    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [46:0] r;
        r = {m, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
        return r[6:0];
    endfunction

    function automatic logic [47:0] cmd_frame(input logic [5:0] ix, input logic [31:0] a);
        return {2'b01, ix, a, ref_crc({2'b01, ix, a}), 1'b1};
    endfunction

    function automatic logic [47:0] rsp_frame(input logic [5:0] ix, input logic [31:0] s);
        return {2'b00, ix, s, ref_crc({2'b00, ix, s}), 1'b1};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    // one card clock: drive the card side, sample the host side before the tick edge
    task automatic sd_cycle(input logic cin, input logic d0);
        @(negedge clk);
        cmd_in = cin; dat0_in = d0; sd_tick = 1'b1;
        s_out = cmd_out; s_oe = cmd_oe; s_ck = sdclk_en;
        @(negedge clk);
        sd_tick = 1'b0; cmd_in = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // reference model of the CMD line: a queue of expected bits, popped per card clock
    task automatic expect_bits(input logic [47:0] f, input int hi, input int lo, inout int bad);
        for (int i = hi; i >= lo; i--) exp_q.push_back(f[i]);
        while (exp_q.size() > 0) begin
            logic b;
            b = exp_q.pop_front();
            sd_cycle(1'b1, 1'b1);
            if (s_oe !== 1'b1 || s_out !== b || s_ck !== 1'b1) bad++;
        end
    endtask

    task automatic expect_frame(input logic [47:0] f, input string tag);
        int bad;
        bad = 0;
        expect_bits(f, 47, 0, bad);
        chk(tag, bad, 0);
    endtask

    task automatic respond(input logic [135:0] r, input int len, input int dly);
        int quiet;
        quiet = 0;
        repeat (dly) begin
            sd_cycle(1'b1, 1'b1);
            if (s_ck !== 1'b1 || s_oe !== 1'b0) quiet++;
        end
        for (int i = len - 1; i >= 0; i--) sd_cycle(r[i], 1'b1);
        chk("R6 clock runs while waiting", quiet, 0);
    endtask

    task automatic finish_seq(input logic [1:0] exp_err, input string tag);
        logic [31:0] st;
        repeat (3) @(negedge clk);
        rd(3'd3, st);
        chk({tag, " R10 done flag"}, st[5], 1'b1);
        chk({tag, " R10 irq high"}, irq, 1'b1);
        chk({tag, " R5/R6/R11 error bits"}, {st[4], st[0]}, exp_err);
        wr(3'd3, 32'h60);
        rd(3'd3, st);
        chk({tag, " R10 W1C clears"}, {st[6], st[5], irq}, 3'b100);
    endtask

    logic [31:0] v;
    logic [47:0] rf;
    logic [135:0] lf;
    int n, bad;

    initial begin : wdog
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd3, v); chk("R1 status", v, 0);
        rd(3'd2, v); chk("R1 control", v, 0);
        rd(3'd4, v); chk("R1 response word", v, 0);
        chk("R1 outputs", {cmd_oe, sdclk_en, irq}, 3'b000);

        wr(3'd3, 32'h40);

        // R9 init clocks, count 5
        wr(3'd2, 32'h0000_0588);
        n = 0; bad = 0;
        for (int k = 0; k < 12; k++) begin
            sd_cycle(1'b1, 1'b1);
            if (s_ck) n++;
            if (s_oe) bad++;
        end
        chk("R9 init clock count", n, 5);
        chk("R9 no command driven", bad, 0);
        finish_seq(2'b00, "init");

        // R2/R3 CMD0, mode 0, known frame
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        wr(3'd2, 32'h80);
        expect_frame(48'h40_0000_0000_95, "R2 CMD0 frame");
        sd_cycle(1'b1, 1'b1);
        chk("R3 no response window", {s_ck, s_oe}, 2'b00);
        finish_seq(2'b00, "mode0");

        // R2/R4 CMD8 mode 1, known frame, response after 2 ticks
        wr(3'd0, 32'h1AA); wr(3'd1, 32'd8);
        wr(3'd2, 32'h81);
        expect_frame(48'h48_0000_01AA_87, "R2 CMD8 frame");
        rf = rsp_frame(6'd8, 32'h0000_01AA);
        respond({88'h0, rf}, 48, 2);
        finish_seq(2'b00, "mode1");
        rd(3'd4, v); chk("R4 word0 layout", v, rf[31:0]);
        rd(3'd5, v); chk("R4 word1 layout", v, {16'h0, rf[47:32]});

        // R5 corrupted response
        wr(3'd2, 32'h81);
        expect_frame(48'h48_0000_01AA_87, "R2 CMD8 again");
        respond({88'h0, rf ^ 48'h10_0000}, 48, 1);
        finish_seq(2'b01, "R5 crc");

        // R11 good run clears previous error
        wr(3'd2, 32'h81);
        expect_frame(48'h48_0000_01AA_87, "R2 CMD8 third");
        respond({88'h0, rf}, 48, 0);
        finish_seq(2'b00, "R11 cleared");

        // R6 timeout: 63 quiet ticks, not yet done; 64th ends it
        wr(3'd0, 32'h1234_5678); wr(3'd1, 32'd13);
        wr(3'd2, 32'h81);
        expect_frame(cmd_frame(6'd13, 32'h1234_5678), "R2 CMD13 frame");
        repeat (63) sd_cycle(1'b1, 1'b1);
        repeat (2) @(negedge clk);
        rd(3'd3, v); chk("R6 no early timeout", {v[5], v[4], v[8]}, 3'b001);
        sd_cycle(1'b1, 1'b1);
        finish_seq(2'b10, "R6 timeout");

        // R6 boundary: start bit on the 64th tick still accepted
        wr(3'd2, 32'h81);
        expect_frame(cmd_frame(6'd13, 32'h1234_5678), "R2 CMD13 again");
        rf = rsp_frame(6'd13, 32'hCAFE_0900);
        respond({88'h0, rf}, 48, 63);
        finish_seq(2'b00, "R6 late start");
        rd(3'd4, v); chk("R6 late response word0", v, rf[31:0]);

        // R7 long response, bad CRC ignored
        wr(3'd0, 32'h0); wr(3'd1, 32'd2);
        wr(3'd2, 32'h82);
        expect_frame(cmd_frame(6'd2, 32'h0), "R2 CMD2 frame");
        lf = {8'h3F, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211};
        respond(lf, 136, 3);
        finish_seq(2'b00, "R7 long");
        rd(3'd4, v); chk("R7 word0", v, 32'h0123_4567);
        rd(3'd5, v); chk("R7 word1", v, 32'h89AB_CDEF);
        rd(3'd6, v); chk("R7 word2", v, 32'hFEDC_BA98);
        rd(3'd7, v); chk("R7 word3", v, 32'h7654_3211);

        // R8 busy wait
        wr(3'd0, 32'h0); wr(3'd1, 32'd12);
        wr(3'd2, 32'h83);
        expect_frame(cmd_frame(6'd12, 32'h0), "R2 CMD12 frame");
        rf = rsp_frame(6'd12, 32'h0000_0B00);
        respond({88'h0, rf}, 48, 1);
        bad = 0;
        repeat (5) begin
            sd_cycle(1'b1, 1'b0);
            if (!s_ck) bad++;
        end
        repeat (2) @(negedge clk);
        rd(3'd3, v);
        chk("R8 no done while DAT0 low", {v[5], bad[0]}, 2'b00);
        sd_cycle(1'b1, 1'b1);
        finish_seq(2'b00, "R8 busy");

        // R4 read-data mode behaves as a short response
        wr(3'd0, 32'h0); wr(3'd1, 32'd17);
        wr(3'd2, 32'h84);
        expect_frame(48'h51_0000_0000_55, "R2 CMD17 frame");
        rf = rsp_frame(6'd17, 32'h0000_0900);
        respond({88'h0, rf}, 48, 2);
        finish_seq(2'b00, "R4 mode4");
        rd(3'd5, v); chk("R4 mode4 word1", v, {16'h0, rf[47:32]});

        // R3 undefined code 6 acts like mode 0
        wr(3'd2, 32'h86);
        expect_frame(48'h51_0000_0000_55, "R3 code6 frame");
        sd_cycle(1'b1, 1'b1);
        chk("R3 code6 no response", {s_ck, s_oe}, 2'b00);
        finish_seq(2'b00, "R3 code6");

        // R12/R13: control write during a run is ignored; delay field kept
        wr(3'd0, 32'h0); wr(3'd1, 32'd0);
        wr(3'd2, 32'h00A5_0080);
        bad = 0;
        rf = 48'h40_0000_0000_95;
        expect_bits(rf, 47, 38, bad);
        wr(3'd2, 32'h005A_0388);
        expect_bits(rf, 37, 0, bad);
        chk("R12 frame undisturbed", bad, 0);
        sd_cycle(1'b1, 1'b1);
        chk("R12 no init burst started", s_ck, 1'b0);
        rd(3'd2, v); chk("R13 control readback", v, 32'h00A5_0000);
        finish_seq(2'b00, "R12 ignore");

        // R10 interrupt disabled
        wr(3'd3, 32'h0);
        wr(3'd2, 32'h0000_0188);
        repeat (3) sd_cycle(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        rd(3'd3, v);
        chk("R10 flag set, irq masked", {v[5], irq}, 2'b10);
        rd(3'd2, v); chk("R13 delay after new run", v[23:16], 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule